// File: doc/BRIEF.md
# Pin Change Interrupt Unit

This unit watches a vector of already synchronized pin levels and records every change of level, rising or falling, in a latched event register. The unit has no notion of pin ownership or pin direction. A pin driven by the GPIO logic, by a peripheral, as an input or as an output produces an event in the same way. Software arms pins through a set/clear pair of mask registers. A single interrupt line is raised while any armed pin has a pending event. Reading the event register returns its contents and empties it in the same cycle.

Each pin can optionally be passed through a small glitch filter before change detection. The filter only accepts a new level once the raw level has held for two consecutive clocks. The filter has its own set/clear pair and a readback register, and it works no matter who drives the pin. Register access uses a single-cycle write strobe and a read strobe. Read data appears on the clock after the read strobe.

Top module: `pin_event_unit`

## Requirements
- R1: After reset the event, mask and filter-enable registers read zero and `irq_o` is low. The first level sampled after reset produces no event.
- R2: A level change on an unfiltered pin, in either direction, sets that pin's event bit at the same clock edge at which the new level is first sampled.
- R3: Writing address 0 sets the mask bits where the write data has ones, and leaves the other bits unchanged. Writing address 1 clears the mask bits where the write data has ones. Address 2 reads the mask back. Writes to address 2 have no effect. Reads of address 0 return zero.
- R4: `irq_o` is high exactly when some event bit is set whose mask bit is also set. An event on an unmasked pin leaves `irq_o` low.
- R5: A read strobe at address 3 returns the event register on `rdata_o` one clock later, and it clears the event register at the same edge.
- R6: A change detected in the same cycle as a read of address 3 remains set after the clear. The read itself returns the contents from before that change.
- R7: Writing address 4 sets the filter-enable bits where the write data has ones. Writing address 5 clears them. Address 6 reads them back.
- R8: On a filtered pin, a level held for only one clock produces no event. A level that holds sets the event bit two clocks later than it would on an unfiltered pin.
- R9: Address 7 reads the level used for change detection: the filtered level for filtered pins and the raw level for the others.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pins_i | input | NPINS | Synchronized pin levels |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the clock after `rd_en_i` |
| irq_o | output | 1 | Interrupt, high while an armed event is pending |

## Verification
The bound checker checks several rules on every cycle. It checks that set and clear writes land on the mask, that a detected change is always latched into the event register even during a clearing read, that a read returns the event register from before the clear, and that the interrupt never rises without both a pending event and a mask bit. Some behaviours show only in the bench's scenarios. These are the reset values, that a writable-looking mask address is ignored, that a one-clock glitch on a filtered pin is rejected, the exact two-clock delay added by the filter, and the level readback.

// File: rtl/pev_pkg.sv
package pev_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_ARM_SET  = 3'd0,
        A_ARM_CLR  = 3'd1,
        A_ARM      = 3'd2,
        A_EVENTS   = 3'd3,
        A_FILT_SET = 3'd4,
        A_FILT_CLR = 3'd5,
        A_FILT     = 3'd6,
        A_LEVEL    = 3'd7
    } pev_addr_e;

endpackage

// File: rtl/pev_filter.sv
module pev_filter #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw_i,
    input  logic [N-1:0] en_i,
    output logic [N-1:0] lvl_o
);

    typedef struct packed {
        logic [N-1:0] raw_prev;
        logic [N-1:0] held;
        logic         armed;
    } flt_st_t;

    flt_st_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.raw_prev = raw_i;
        st_d.armed    = 1'b1;
        for (int i = 0; i < N; i++) begin
            if (!st_q.armed) begin
                st_d.held[i] = raw_i[i];
            end else if (raw_i[i] == st_q.raw_prev[i]) begin
                st_d.held[i] = raw_i[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_sel
        assign lvl_o[g] = en_i[g] ? st_q.held[g] : raw_i[g];
    end

endmodule

// File: rtl/pev_change.sv
module pev_change #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl_i,
    output logic [N-1:0] chg_o
);

    typedef struct packed {
        logic [N-1:0] prev;
        logic         armed;
    } chg_st_t;

    chg_st_t st_d, st_q;

    always_comb begin
        st_d.prev  = lvl_i;
        st_d.armed = 1'b1;
        chg_o      = st_q.armed ? (lvl_i ^ st_q.prev) : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/pev_regs.sv
module pev_regs
    import pev_pkg::*;
#(
    parameter int N = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [N-1:0]      chg_i,
    input  logic [N-1:0]      lvl_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [N-1:0]      arm_o,
    output logic [N-1:0]      events_o,
    output logic [N-1:0]      filt_o,
    output logic              irq_o
);

    typedef struct packed {
        logic [N-1:0]      arm;
        logic [N-1:0]      events;
        logic [N-1:0]      filt;
        logic [DATA_W-1:0] rdata;
    } reg_st_t;

    reg_st_t st_d, st_q;

    function automatic logic [DATA_W-1:0] widen(input logic [N-1:0] v);
        widen        = '0;
        widen[N-1:0] = v;
    endfunction

    logic [N-1:0] wbits;
    logic         ev_read;

    assign wbits   = wdata_i[N-1:0];
    assign ev_read = rd_en_i && (addr_i == A_EVENTS);

    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            unique case (addr_i)
                A_ARM_SET:  st_d.arm  = st_q.arm | wbits;
                A_ARM_CLR:  st_d.arm  = st_q.arm & ~wbits;
                A_FILT_SET: st_d.filt = st_q.filt | wbits;
                A_FILT_CLR: st_d.filt = st_q.filt & ~wbits;
                default: ;
            endcase
        end
        st_d.events = (ev_read ? '0 : st_q.events) | chg_i;
        st_d.rdata  = '0;
        if (rd_en_i) begin
            unique case (addr_i)
                A_ARM:    st_d.rdata = widen(st_q.arm);
                A_EVENTS: st_d.rdata = widen(st_q.events);
                A_FILT:   st_d.rdata = widen(st_q.filt);
                A_LEVEL:  st_d.rdata = widen(lvl_i);
                default:  st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata_o  = st_q.rdata;
    assign arm_o    = st_q.arm;
    assign events_o = st_q.events;
    assign filt_o   = st_q.filt;
    assign irq_o    = |(st_q.events & st_q.arm);

endmodule

// File: rtl/pin_event_unit.sv
module pin_event_unit
    import pev_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NPINS-1:0]     pins_i,
    input  logic                 wr_en_i,
    input  logic                 rd_en_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [DATA_W-1:0]    wdata_i,
    output logic [DATA_W-1:0]    rdata_o,
    output logic                 irq_o
);

    logic [NPINS-1:0] lvl_w;
    logic [NPINS-1:0] chg_w;
    logic [NPINS-1:0] arm_w;
    logic [NPINS-1:0] events_w;
    logic [NPINS-1:0] filt_w;

    pev_filter #(.N(NPINS)) filter_i (
        .clk   (clk),
        .rst_n (rst_n),
        .raw_i (pins_i),
        .en_i  (filt_w),
        .lvl_o (lvl_w)
    );

    pev_change #(.N(NPINS)) change_i (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl_i (lvl_w),
        .chg_o (chg_w)
    );

    pev_regs #(.N(NPINS)) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (wr_en_i),
        .rd_en_i  (rd_en_i),
        .addr_i   (addr_i),
        .wdata_i  (wdata_i),
        .chg_i    (chg_w),
        .lvl_i    (lvl_w),
        .rdata_o  (rdata_o),
        .arm_o    (arm_w),
        .events_o (events_w),
        .filt_o   (filt_w),
        .irq_o    (irq_o)
    );

endmodule

// File: rtl/pev_chk.sv
module pev_chk
    import pev_pkg::*;
#(
    parameter int N = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en_i,
    input logic              rd_en_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [DATA_W-1:0] wdata_i,
    input logic [DATA_W-1:0] rdata_o,
    input logic              irq_o,
    input logic [N-1:0]      chg,
    input logic [N-1:0]      arm,
    input logic [N-1:0]      events
);

    // R1
    reset_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (events == '0 && arm == '0 && !irq_o));

    // R3
    arm_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == A_ARM_SET) |=>
            ((arm & $past(wdata_i[N-1:0])) == $past(wdata_i[N-1:0])));

    // R3
    arm_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == A_ARM_CLR) |=>
            ((arm & $past(wdata_i[N-1:0])) == '0));

    // R5
    event_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && addr_i == A_EVENTS) |=> (rdata_o[N-1:0] == $past(events)));

    // R6
    change_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chg != '0) |=> ((events & $past(chg)) == $past(chg)));

    // R4
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (arm != '0 && events != '0));

endmodule

bind pin_event_unit pev_chk #(.N(NPINS)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en_i (wr_en_i),
    .rd_en_i (rd_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .irq_o   (irq_o),
    .chg     (chg_w),
    .arm     (arm_w),
    .events  (events_w)
);

// File: tb/pin_event_unit_tb_top.sv
module pin_event_unit_tb_top;
    import pev_pkg::*;

    localparam int NP = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NP-1:0]     pins = '0;
    logic              wr_en = 1'b0;
    logic              rd_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic [DATA_W-1:0] rdata;
    logic              irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic fire = 1'b0;

    logic [DATA_W-1:0] exp_q[$];
    string             tag_q[$];

    always #10 clk = ~clk;

    pin_event_unit #(.NPINS(NP)) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .pins_i  (pins),
        .wr_en_i (wr_en),
        .rd_en_i (rd_en),
        .addr_i  (addr),
        .wdata_i (wdata),
        .rdata_o (rdata),
        .irq_o   (irq)
    );

    // monitor: read data is due one edge after the strobe
    always @(posedge clk) fire <= rd_en && rst_n;

    always @(negedge clk) begin
        if (fire) begin
            n_cmp++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL scoreboard: unexpected read data actual=%h expected=none", rdata);
            end else begin
                automatic logic [DATA_W-1:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                if (rdata !== e) begin
                    n_bad++;
                    $display("FAIL %s: rdata actual=%h expected=%h", t, rdata, e);
                end
            end
        end
    end

    task automatic wr(input pev_addr_e a, input logic [DATA_W-1:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input pev_addr_e a, input logic [DATA_W-1:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string t);
        n_cmp++;
        if (irq !== e) begin
            n_bad++;
            $display("FAIL %s: irq actual=%b expected=%b", t, irq, e);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            report();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk_irq(1'b0, "R1");
        rd(A_ARM, 32'h0, "R1 mask");
        rd(A_EVENTS, 32'h0, "R1 events");
        rd(A_FILT, 32'h0, "R1 filter");

        // R3 set/clear mask
        wr(A_ARM_SET, 32'h0000_00FF);
        rd(A_ARM, 32'h0000_00FF, "R3 set");
        wr(A_ARM_CLR, 32'h0000_000F);
        rd(A_ARM, 32'h0000_00F0, "R3 clear");
        wr(A_ARM, 32'hFFFF_FFFF);
        rd(A_ARM, 32'h0000_00F0, "R3 readonly");
        rd(A_ARM_SET, 32'h0, "R3 writeonly");

        // R2 rising change, R4 masked irq, R5 clear on read
        pins = 32'h0000_0011;
        @(negedge clk);
        chk_irq(1'b1, "R4 armed event");
        rd(A_EVENTS, 32'h0000_0011, "R2 rising / R5");
        chk_irq(1'b0, "R5 cleared irq");
        rd(A_EVENTS, 32'h0, "R5 empty");

        // R2 falling change on an unarmed pin, R4 stays low
        pins = 32'h0000_0010;
        @(negedge clk);
        chk_irq(1'b0, "R4 unarmed");
        rd(A_EVENTS, 32'h0000_0001, "R2 falling");

        // R6 change during a clearing read
        pins = 32'h0000_0030;
        rd(A_EVENTS, 32'h0, "R6 old contents");
        chk_irq(1'b1, "R6 kept irq");
        rd(A_EVENTS, 32'h0000_0020, "R6 kept");

        // R7 filter enable pair
        wr(A_FILT_SET, 32'h0000_0300);
        rd(A_FILT, 32'h0000_0300, "R7 set");
        wr(A_FILT_CLR, 32'h0000_0200);
        rd(A_FILT, 32'h0000_0100, "R7 clear");
        wr(A_ARM_SET, 32'h0000_0100);

        // R8 one-clock glitch rejected
        pins = 32'h0000_0130;
        @(negedge clk);
        pins = 32'h0000_0030;
        repeat (3) @(negedge clk);
        chk_irq(1'b0, "R8 glitch");
        rd(A_EVENTS, 32'h0, "R8 glitch");

        // R8 held level accepted two clocks late
        pins = 32'h0000_0130;
        @(negedge clk);
        @(negedge clk);
        chk_irq(1'b0, "R8 not yet");
        @(negedge clk);
        chk_irq(1'b1, "R8 accepted");

        // R9 level readback
        rd(A_LEVEL, 32'h0000_0130, "R9 level");
        rd(A_EVENTS, 32'h0000_0100, "R8 event");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard: pending actual=%0d expected=0", exp_q.size());
        end
        done = 1'b1;
        report();
    end

endmodule